// File: doc/BRIEF.md
# Gate Pulse Controller with Integrating Overload Timer

This block drives the gate of a switching power stage. Every rising edge of a period-start strobe opens one drive pulse, unless a fault is latched. The pulse closes on the first of four events: the PWM comparator flag, the current-limit comparator flag, the short-circuit comparator flag, or a maximum on-time. The maximum on-time is set to a fixed share of the switching period, 80 % by default. The two current flags cut the drive output in the same clock cycle they are seen. The PWM flag and the on-time limit close the pulse at the next clock edge.

The block remembers why the last pulse ended and feeds that into an overload timer. After a pulse cut by a current flag, the timer climbs by one every clock. After a pulse closed by the PWM flag or by the on-time limit, it falls by a configurable step every clock and stops at zero. It never jumps back to zero on its own, so short overloads are tolerated while a sustained one builds up. When the timer reaches the timeout, a fault latches and holds the drive low. The timeout is given in microseconds and turned into clock ticks from the clock rate. Only the fault-clear input releases the fault, and it also empties the timer.

Top module: `gate_pulse_ctrl`

## Requirements
- R1: After reset, gate_o, fault_o and ovl_timer_o are all zero.
- R2: A 0-to-1 transition of period_start_i, sampled at a clock edge, raises gate_o from that edge onward. A strobe held high opens only one pulse.
- R3: pwm_trip_i, sampled high at a clock edge during a pulse, ends the pulse at that edge. gate_o stays high in the cycle the flag is first applied.
- R4: ilim_trip_i forces gate_o low in the same cycle it is high, and ends the pulse at the next edge.
- R5: short_trip_i forces gate_o low in the same cycle it is high, and ends the pulse at the next edge.
- R6: A pulse that no flag ends lasts exactly MAX_ON = PERIOD_TICKS*MAX_DUTY_PCT/100 clock cycles.
- R7: After a pulse ended by ilim_trip_i or short_trip_i, ovl_timer_o rises by exactly 1 per clock, starting one edge after the ending edge.
- R8: After a pulse ended by pwm_trip_i or by the on-time limit, ovl_timer_o falls by DOWN_STEP per clock. It saturates at 0 and never wraps.
- R9: If ilim_trip_i and pwm_trip_i are high in the same cycle, the pulse counts as current-limited and the timer rises.
- R10: One edge after ovl_timer_o equals LIMIT = CLK_KHZ*TIMEOUT_US/1000, fault_o goes high and stays high. While fault_o is high, gate_o is low and period strobes are ignored.
- R11: fault_clr_i, sampled high, zeroes fault_o and ovl_timer_o at that edge, sets the timer direction to falling, and lets new pulses start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_start_i | input | 1 | Period-start strobe; its rising edge opens a pulse |
| pwm_trip_i | input | 1 | Synchronized PWM comparator flag |
| ilim_trip_i | input | 1 | Synchronized current-limit comparator flag |
| short_trip_i | input | 1 | Synchronized short-circuit comparator flag |
| fault_clr_i | input | 1 | Clears the fault and the overload timer |
| gate_o | output | 1 | Gate drive output |
| fault_o | output | 1 | Latched overload fault |
| ovl_timer_o | output | TMR_W | Overload timer value |

## Verification
Pulses are ended in turn by each of the four events, and each ending is checked at the cycle it must show. This separates the same-cycle cut of the two current flags from the one-edge delay of the PWM flag and the on-time limit. After a current-limited pulse, the timer is watched climbing. After a PWM-ended pulse, it is watched falling into saturation at zero, which proves integration rather than reset. A simultaneous current and PWM trip checks priority. An overload held to the timeout checks the exact cycle the fault latches, that strobes are then blocked, and that fault-clear restores pulsing.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

    // Cause of the end of a drive pulse.
    typedef enum logic [2:0] {
        END_NONE  = 3'd0,
        END_PWM   = 3'd1,
        END_ILIM  = 3'd2,
        END_SHORT = 3'd3,
        END_MAXD  = 3'd4
    } end_cause_e;

    // True when the end cause counts as an overload for the timer.
    function automatic logic is_overload(input end_cause_e c);
        return (c == END_ILIM) || (c == END_SHORT);
    endfunction

endpackage

// File: rtl/gpc_pulse_gen.sv
module gpc_pulse_gen
    import gpc_pkg::*;
#(
    parameter int MAX_ON = 800,
    localparam int ON_W  = $clog2(MAX_ON + 1)
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic       pwm_trip_i,
    input  logic       ilim_trip_i,
    input  logic       short_trip_i,
    input  logic       fault_i,
    output logic       gate_o,
    output logic       end_valid_o,
    output end_cause_e end_cause_o
);

    typedef struct packed {
        logic            drive;
        logic            start_prev;
        logic [ON_W-1:0] on_cnt;
    } pg_state_t;

    pg_state_t  st_d, st_q;
    end_cause_e cause;
    logic       start_rise;
    logic       max_hit;

    always_comb begin
        st_d       = st_q;
        start_rise = start_i && !st_q.start_prev;
        max_hit    = st_q.drive && (st_q.on_cnt == ON_W'(MAX_ON - 1));

        // Current flags outrank the PWM flag, which outranks the duty limit.
        if (!st_q.drive)       cause = END_NONE;
        else if (short_trip_i) cause = END_SHORT;
        else if (ilim_trip_i)  cause = END_ILIM;
        else if (pwm_trip_i)   cause = END_PWM;
        else if (max_hit)      cause = END_MAXD;
        else                   cause = END_NONE;

        st_d.start_prev = start_i;

        if (fault_i) begin
            st_d.drive  = 1'b0;
            st_d.on_cnt = '0;
        end else if (st_q.drive) begin
            if (cause != END_NONE) begin
                st_d.drive  = 1'b0;
                st_d.on_cnt = '0;
            end else begin
                st_d.on_cnt = st_q.on_cnt + 1'b1;
            end
        end else if (start_rise) begin
            st_d.drive  = 1'b1;
            st_d.on_cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // Current trips cut the output inside the same cycle.
    assign gate_o      = st_q.drive && !ilim_trip_i && !short_trip_i && !fault_i;
    assign end_valid_o = (cause != END_NONE);
    assign end_cause_o = cause;

endmodule

// File: rtl/gpc_ovl_timer.sv
module gpc_ovl_timer
    import gpc_pkg::*;
#(
    parameter int                 TMR_W     = 22,
    parameter logic [TMR_W-1:0]   LIMIT     = '1,
    parameter int                 DOWN_STEP = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             end_valid_i,
    input  end_cause_e       end_cause_i,
    input  logic             clr_i,
    output logic [TMR_W-1:0] timer_o,
    output logic             at_limit_o
);

    localparam logic [TMR_W-1:0] STEP = TMR_W'(DOWN_STEP);

    typedef struct packed {
        logic             dir_up;
        logic [TMR_W-1:0] count;
    } ot_state_t;

    ot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        if (st_q.dir_up) begin
            if (st_q.count < LIMIT) st_d.count = st_q.count + 1'b1;
        end else begin
            if (st_q.count > STEP) st_d.count = st_q.count - STEP;
            else                   st_d.count = '0;
        end

        if (end_valid_i) st_d.dir_up = is_overload(end_cause_i);

        if (clr_i) begin
            st_d.dir_up = 1'b0;
            st_d.count  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign timer_o    = st_q.count;
    assign at_limit_o = (st_q.count >= LIMIT);

endmodule

// File: rtl/gpc_fault_latch.sv
module gpc_fault_latch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic fault_o
);

    typedef struct packed {
        logic fault;
    } fl_state_t;

    fl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)      st_d.fault = 1'b0;
        else if (set_i) st_d.fault = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fault_o = st_q.fault;

endmodule

// File: rtl/gate_pulse_ctrl.sv
module gate_pulse_ctrl
    import gpc_pkg::*;
#(
    parameter int  CLK_KHZ      = 100000,
    parameter int  TIMEOUT_US   = 30000,
    parameter int  PERIOD_TICKS = 1000,
    parameter int  MAX_DUTY_PCT = 80,
    parameter int  DOWN_STEP    = 1,
    localparam longint LIM_L    = longint'(CLK_KHZ) * longint'(TIMEOUT_US) / 1000,
    localparam int TMR_W        = $clog2(LIM_L + 1),
    localparam int MAX_ON       = PERIOD_TICKS * MAX_DUTY_PCT / 100
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             period_start_i,
    input  logic             pwm_trip_i,
    input  logic             ilim_trip_i,
    input  logic             short_trip_i,
    input  logic             fault_clr_i,
    output logic             gate_o,
    output logic             fault_o,
    output logic [TMR_W-1:0] ovl_timer_o
);

    localparam logic [TMR_W-1:0] LIMIT_V = TMR_W'(LIM_L);

    logic       end_valid;
    end_cause_e end_cause;
    logic       at_limit;

    gpc_pulse_gen #(
        .MAX_ON(MAX_ON)
    ) u_pulse (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (period_start_i),
        .pwm_trip_i  (pwm_trip_i),
        .ilim_trip_i (ilim_trip_i),
        .short_trip_i(short_trip_i),
        .fault_i     (fault_o),
        .gate_o      (gate_o),
        .end_valid_o (end_valid),
        .end_cause_o (end_cause)
    );

    gpc_ovl_timer #(
        .TMR_W    (TMR_W),
        .LIMIT    (LIMIT_V),
        .DOWN_STEP(DOWN_STEP)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .end_valid_i(end_valid),
        .end_cause_i(end_cause),
        .clr_i      (fault_clr_i),
        .timer_o    (ovl_timer_o),
        .at_limit_o (at_limit)
    );

    gpc_fault_latch u_fault (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (at_limit),
        .clr_i  (fault_clr_i),
        .fault_o(fault_o)
    );

endmodule

// File: rtl/gpc_checker.sv
module gpc_checker #(
    parameter int               MAX_ON = 800,
    parameter int               TMR_W  = 22,
    parameter logic [TMR_W-1:0] LIMIT  = '1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             period_start_i,
    input logic             ilim_trip_i,
    input logic             fault_clr_i,
    input logic             gate_o,
    input logic             fault_o,
    input logic [TMR_W-1:0] ovl_timer_o
);

    localparam int W_W = $clog2(MAX_ON + 2);

    logic [W_W-1:0] width_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     width_q <= '0;
        else if (gate_o) width_q <= width_q + 1'b1;
        else             width_q <= '0;
    end

    // R2
    start_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_o) |-> ($past(period_start_i) && !$past(period_start_i, 2)));

    // R4
    ilim_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ilim_trip_i |-> !gate_o);

    // R6
    max_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        width_q <= W_W'(MAX_ON));

    // R8
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovl_timer_o <= LIMIT);

    // R7
    step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_clr_i |=> (ovl_timer_o <= $past(ovl_timer_o) + 1'b1));

    // R10
    fault_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> !gate_o);

    // R11
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_clr_i |=> (!fault_o && ovl_timer_o == '0));

endmodule

bind gate_pulse_ctrl gpc_checker #(
    .MAX_ON(MAX_ON),
    .TMR_W (TMR_W),
    .LIMIT (LIMIT_V)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .period_start_i(period_start_i),
    .ilim_trip_i   (ilim_trip_i),
    .fault_clr_i   (fault_clr_i),
    .gate_o        (gate_o),
    .fault_o       (fault_o),
    .ovl_timer_o   (ovl_timer_o)
);

// File: tb/gate_pulse_ctrl_bench.sv
module gate_pulse_ctrl_bench;

    localparam int CLK_KHZ   = 100000;
    localparam int TIMEOUT_U = 1;
    localparam int PERIOD    = 20;
    localparam int DUTY      = 80;
    localparam int STEP      = 3;
    localparam int MAXON     = PERIOD * DUTY / 100;          // 16
    localparam int LIM       = CLK_KHZ * TIMEOUT_U / 1000;   // 100
    localparam int TW        = $clog2(LIM + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          pwm = 1'b0;
    logic          ilim = 1'b0;
    logic          shrt = 1'b0;
    logic          clr = 1'b0;
    logic          gate;
    logic          fault;
    logic [TW-1:0] tmr;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    gate_pulse_ctrl #(
        .CLK_KHZ     (CLK_KHZ),
        .TIMEOUT_US  (TIMEOUT_U),
        .PERIOD_TICKS(PERIOD),
        .MAX_DUTY_PCT(DUTY),
        .DOWN_STEP   (STEP)
    ) u_gate_pulse_ctrl (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .period_start_i(start),
        .pwm_trip_i    (pwm),
        .ilim_trip_i   (ilim),
        .short_trip_i  (shrt),
        .fault_clr_i   (clr),
        .gate_o        (gate),
        .fault_o       (fault),
        .ovl_timer_o   (tmr)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Opens a pulse; returns at the negedge where gate should be high.
    task automatic open_pulse(input string req);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(req, gate, 1);
    endtask

    task automatic t_reset();
        check("R1 gate", gate, 0);
        check("R1 fault", fault, 0);
        check("R1 timer", tmr, 0);
    endtask

    task automatic t_max_duty();
        int w = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk);
        check("R2 start latency", gate, 1);
        for (int i = 0; i < 30; i++) begin
            if (gate) w++;
            @(negedge clk);
        end
        check("R6 pulse width", w, MAXON);
        check("R2 held strobe single pulse", gate, 0);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_pwm_end();
        open_pulse("R2 pwm pulse");
        @(negedge clk); @(negedge clk);
        pwm = 1'b1;
        #1 check("R3 gate high while pwm first applied", gate, 1);
        @(negedge clk); pwm = 1'b0;
        check("R3 pulse ended", gate, 0);
    endtask

    task automatic t_short();
        open_pulse("R2 short pulse");
        shrt = 1'b1;
        #1 check("R5 same cycle cut", gate, 0);
        @(negedge clk); shrt = 1'b0;
        #1 check("R5 pulse ended", gate, 0);
        clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check("R11 clear timer", tmr, 0);
        check("R11 clear fault", fault, 0);
        repeat (3) @(negedge clk);
        check("R11 direction falling after clear", tmr, 0);
    endtask

    task automatic t_ilim_up();
        open_pulse("R2 ilim pulse");
        ilim = 1'b1;
        #1 check("R4 same cycle cut", gate, 0);
        @(negedge clk); ilim = 1'b0;
        #1 check("R4 pulse ended", gate, 0);
        check("R7 timer at ending edge", tmr, 0);
        repeat (10) @(negedge clk);
        check("R7 timer after 10 clocks", tmr, 10);
    endtask

    task automatic t_pwm_down();
        int t0;
        open_pulse("R2 down pulse");
        pwm = 1'b1;
        @(negedge clk); pwm = 1'b0;
        t0 = int'(tmr);
        for (int k = 1; k <= 8; k++) begin
            int e;
            @(negedge clk);
            e = t0 - STEP * k;
            if (e < 0) e = 0;
            check("R8 falling and saturating", tmr, e);
        end
    endtask

    task automatic t_priority();
        open_pulse("R2 priority pulse");
        ilim = 1'b1; pwm = 1'b1;
        @(negedge clk); ilim = 1'b0; pwm = 1'b0;
        check("R9 timer at ending edge", tmr, 0);
        repeat (5) @(negedge clk);
        check("R9 timer rising", tmr, 5);
    endtask

    task automatic t_fault();
        int guard = 0;
        while (int'(tmr) != LIM && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        check("R10 timer reaches limit", tmr, LIM);
        check("R10 no fault at limit cycle", fault, 0);
        @(negedge clk);
        check("R10 fault set", fault, 1);
        check("R10 timer held", tmr, LIM);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 strobe ignored", gate, 0);
        end
        check("R10 fault latched", fault, 1);
        clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check("R11 fault cleared", fault, 0);
        check("R11 timer cleared", tmr, 0);
        open_pulse("R11 pulse resumes");
        pwm = 1'b1;
        @(negedge clk); pwm = 1'b0;
        check("R11 resumed pulse ended", gate, 0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_max_duty();
        t_pwm_end();
        t_short();
        t_ilim_up();
        t_pwm_down();
        t_priority();
        t_fault();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule